// File: doc/BRIEF.md
# Single-Bit Test Flag Unit

This block performs the flag side of an 8-bit processor's "test one bit" operation. It gets the operand byte (already fetched by other logic, from a register or from memory), the second opcode byte and the carry bit of the current flag byte. It works out the new flag byte, and that value is loaded into a flag register when a valid strobe marks the operation. The operand is only read and never written back.

The opcode carries three fields. Bits 7:6 hold the group code 01 that marks the operation. Bits 5:3 hold the index of the bit to test. Bits 2:0 hold the source selector, which the block passes out for the fetch logic and otherwise ignores. Flags use a fixed byte layout, from bit 7 down to bit 0: S, Z, F5, H, F3, PV, N, C. The zero flag and the parity/overflow flag both show whether the tested bit is clear. The sign flag and the two undocumented copy flags (F5 and F3) report a set tested bit only when its index is 7, 5 or 3 respectively.

Top module: `bitprobe_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `flags_out` is 0x00. `op_hit` is low whenever `op_valid` is low.
- R2: `op_hit` is high in the same cycle exactly when `op_valid` is high and opcode bits 7:6 equal 01. `src_sel` always equals opcode bits 2:0.
- R3: The tested index is opcode bits 5:3. After an accepted operation, Z (flag bit 6) is 1 when that operand bit is 0 and 0 when it is 1.
- R4: After an accepted operation, PV (flag bit 2) equals Z.
- R5: After an accepted operation, H (flag bit 4) is 1 and N (flag bit 1) is 0.
- R6: After an accepted operation, C (flag bit 0) equals `carry_in` as it was in the cycle of the operation.
- R7: When the tested bit is 0, S (bit 7), F5 (bit 5) and F3 (bit 3) are all 0.
- R8: When the tested bit is 1, S is 1 only for index 7, F5 only for index 5 and F3 only for index 3. Otherwise they are 0.
- R9: `flags_out` changes only on the clock edge after a cycle with `op_hit` high. A cycle with `op_valid` low, or with a valid opcode outside group 01, leaves it unchanged.
- R10: Opcode bits 2:0 and the operand bits other than the tested one have no effect on the flag result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe marking an operation in this cycle |
| opcode | input | 8 | Second opcode byte: group, bit index, source selector |
| operand | input | 8 | Byte whose bit is tested |
| carry_in | input | 1 | Carry bit of the current flag byte |
| op_hit | output | 1 | Valid operation recognised as a bit test |
| src_sel | output | 3 | Source selector field for the operand fetch logic |
| flags_out | output | 8 | Flag register S,Z,F5,H,F3,PV,N,C |

## Verification
The bench uses the default parameters: an 8-bit operand, a 3-bit index field starting at opcode bit 3, and group code 01. With these values all eight indices can be reached, including the three that report into S, F5 and F3. So the directed pass tests every index with its bit set and with its bit clear, and with the other operand bits set to the opposite value. Random opcodes across the full byte range also hit the three non-matching group codes and cycles with the strobe low, which exercises the hold behaviour.

// File: rtl/bitprobe_pkg.sv
package bitprobe_pkg;

    localparam int OPR_W    = 8;
    localparam int OPC_W    = 8;
    localparam int FLAG_W   = 8;
    localparam int IDX_LSB  = 3;
    localparam int SEL_W    = 3;
    localparam logic [1:0] GRP_CODE = 2'b01;

    // operand bit positions that are mirrored into dedicated flags
    localparam int S_POS    = 7;
    localparam int F5_POS   = 5;
    localparam int F3_POS   = 3;

    typedef struct packed {
        logic s;
        logic z;
        logic f5;
        logic h;
        logic f3;
        logic pv;
        logic n;
        logic c;
    } flag_t;

    function automatic flag_t build_flags(input logic bit_set,
                                          input logic at_s,
                                          input logic at_f5,
                                          input logic at_f3,
                                          input logic carry);
        flag_t f;
        f.s  = bit_set & at_s;
        f.z  = ~bit_set;
        f.f5 = bit_set & at_f5;
        f.h  = 1'b1;
        f.f3 = bit_set & at_f3;
        f.pv = ~bit_set;
        f.n  = 1'b0;
        f.c  = carry;
        return f;
    endfunction

endpackage

// File: rtl/bitprobe_decode.sv
module bitprobe_decode
    import bitprobe_pkg::*;
#(
    parameter int OPC_BITS = OPC_W,
    parameter int IDX_BITS = 3,
    parameter int IDX_BASE = IDX_LSB,
    parameter int SEL_BITS = SEL_W,
    parameter logic [1:0] GROUP = GRP_CODE
) (
    input  logic [OPC_BITS-1:0] opcode,
    input  logic                valid,
    output logic                hit,
    output logic [IDX_BITS-1:0] idx,
    output logic [SEL_BITS-1:0] sel
);
    localparam int GRP_LSB = OPC_BITS - 2;

    logic [1:0] grp_field;

    always_comb begin
        grp_field = opcode[GRP_LSB +: 2];
        hit       = valid && (grp_field == GROUP);
        idx       = opcode[IDX_BASE +: IDX_BITS];
        sel       = opcode[SEL_BITS-1:0];
    end

endmodule

// File: rtl/bitprobe_eval.sv
module bitprobe_eval
    import bitprobe_pkg::*;
#(
    parameter int DATA_W = OPR_W,
    parameter int IDX_BITS = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]   operand,
    input  logic [IDX_BITS-1:0] idx,
    input  logic                carry,
    output flag_t               result
);
    logic [DATA_W-1:0] pick;
    logic              bit_set;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_pick
            assign pick[gi] = (idx == IDX_BITS'(gi));
        end
    endgenerate

    always_comb begin
        bit_set = |(operand & pick);
        result  = build_flags(bit_set, pick[S_POS], pick[F5_POS],
                              pick[F3_POS], carry);
    end

    // R7: a clear tested bit never reports into S/F5/F3
    always_comb begin
        if (!bit_set)
            a_r7_quiet_when_clear: assert ({result.s, result.f5, result.f3} == 3'b000);
    end

endmodule

// File: rtl/bitprobe_flag_reg.sv
module bitprobe_flag_reg
    import bitprobe_pkg::*;
#(
    parameter int WIDTH = FLAG_W,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (load)
            q <= d;
    end

    // R9: no load, no change
    a_r9_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/bitprobe_top.sv
module bitprobe_top
    import bitprobe_pkg::*;
#(
    parameter int DATA_W = OPR_W,
    parameter int OPC_BITS = OPC_W,
    parameter int SEL_BITS = SEL_W,
    parameter int IDX_BASE = IDX_LSB,
    parameter logic [1:0] GROUP = GRP_CODE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [OPC_BITS-1:0] opcode,
    input  logic [DATA_W-1:0]   operand,
    input  logic                carry_in,
    output logic                op_hit,
    output logic [SEL_BITS-1:0] src_sel,
    output logic [FLAG_W-1:0]   flags_out
);
    localparam int IDX_BITS = $clog2(DATA_W);

    logic [IDX_BITS-1:0] bit_idx;
    flag_t               next_flags;
    flag_t               cur_flags;

    bitprobe_decode #(
        .OPC_BITS (OPC_BITS),
        .IDX_BITS (IDX_BITS),
        .IDX_BASE (IDX_BASE),
        .SEL_BITS (SEL_BITS),
        .GROUP    (GROUP)
    ) u_decode (
        .opcode (opcode),
        .valid  (op_valid),
        .hit    (op_hit),
        .idx    (bit_idx),
        .sel    (src_sel)
    );

    bitprobe_eval #(
        .DATA_W   (DATA_W),
        .IDX_BITS (IDX_BITS)
    ) u_eval (
        .operand (operand),
        .idx     (bit_idx),
        .carry   (carry_in),
        .result  (next_flags)
    );

    bitprobe_flag_reg #(
        .WIDTH   (FLAG_W),
        .RST_VAL ('0)
    ) u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (op_hit),
        .d    (next_flags),
        .q    (flags_out)
    );

    assign cur_flags = flag_t'(flags_out);

    a_r5_h_set_n_clear: assert property (@(posedge clk) disable iff (rst)
        op_hit |=> (cur_flags.h && !cur_flags.n));

    a_r6_carry_passed: assert property (@(posedge clk) disable iff (rst)
        op_hit |=> (cur_flags.c == $past(carry_in)));

    a_r4_pv_tracks_z: assert property (@(posedge clk) disable iff (rst)
        op_hit |=> (cur_flags.pv == cur_flags.z));

    a_r8_single_report: assert property (@(posedge clk) disable iff (rst)
        op_hit |=> $onehot0({cur_flags.s, cur_flags.f5, cur_flags.f3}));

    a_r7_zero_silences: assert property (@(posedge clk) disable iff (rst)
        (op_hit ##1 cur_flags.z) |-> !(cur_flags.s || cur_flags.f5 || cur_flags.f3));

    a_r1_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !op_hit);

endmodule

// File: tb/bitprobe_top_bench.sv
module bitprobe_top_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [7:0] opcode;
    logic [7:0] operand;
    logic       carry_in;
    logic       op_hit;
    logic [2:0] src_sel;
    logic [7:0] flags_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_flags;
    bit done = 0;

    always #4 clk = ~clk;

    bitprobe_top u_bitprobe_top (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .opcode    (opcode),
        .operand   (operand),
        .carry_in  (carry_in),
        .op_hit    (op_hit),
        .src_sel   (src_sel),
        .flags_out (flags_out)
    );

    function automatic logic [7:0] ref_flags(input logic [7:0] opr,
                                             input logic [2:0] ix,
                                             input logic cy);
        logic b;
        b = opr[ix];
        return {b && ix == 3'd7, !b, b && ix == 3'd5, 1'b1,
                b && ix == 3'd3, !b, 1'b0, cy};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    // drive one cycle at negedge, check hit before the edge and flags after it
    task automatic step(input logic v, input logic [7:0] opc,
                        input logic [7:0] opr, input logic cy, input string req);
        logic exp_hit;
        @(negedge clk);
        op_valid = v; opcode = opc; operand = opr; carry_in = cy;
        #1;
        exp_hit = v && (opc[7:6] == 2'b01);
        check("R2 hit", {7'd0, op_hit}, {7'd0, exp_hit});
        check("R2 sel", {5'd0, src_sel}, {5'd0, opc[2:0]});
        if (exp_hit) exp_flags = ref_flags(opr, opc[5:3], cy);
        @(negedge clk);
        op_valid = 1'b0;
        check(req, flags_out, exp_flags);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; op_valid = 1'b0; opcode = 8'h00; operand = 8'h00; carry_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", flags_out, 8'h00);
        check("R1 hit low", {7'd0, op_hit}, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", flags_out, 8'h00);
        exp_flags = 8'h00;

        // R3 R7 R8 R10: every index, bit set and clear, other bits opposite
        for (int i = 0; i < 8; i++) begin
            step(1'b1, {2'b01, 3'(i), 3'(i)}, 8'(1 << i), 1'b0, "R3/R8 bit set");
            step(1'b1, {2'b01, 3'(i), 3'(7 - i)}, ~8'(1 << i), 1'b1, "R3/R7 bit clear");
        end
        // R4 R5: all-ones and all-zero operands
        step(1'b1, 8'h7F, 8'hFF, 1'b1, "R4/R5 index7 ones");
        step(1'b1, 8'h5D, 8'h00, 1'b0, "R4/R5 index3 zeros");
        // R6: carry toggles only C
        step(1'b1, 8'h68, 8'h20, 1'b1, "R6 carry one");
        step(1'b1, 8'h68, 8'h20, 1'b0, "R6 carry zero");
        // R9: outside group and strobe low leave flags alone
        step(1'b1, 8'h00, 8'h00, 1'b1, "R9 group 00");
        step(1'b1, 8'h87, 8'hFF, 1'b0, "R9 group 10");
        step(1'b1, 8'hC0, 8'h00, 1'b1, "R9 group 11");
        step(1'b0, 8'h47, 8'h00, 1'b1, "R9 strobe low");
        // R10: selector bits change nothing
        step(1'b1, 8'h50, 8'hFB, 1'b1, "R10 sel 0");
        step(1'b1, 8'h57, 8'hFB, 1'b1, "R10 sel 7");

        for (int k = 0; k < 400; k++) begin
            step(1'($urandom % 4 != 0), 8'($urandom), 8'($urandom), 1'($urandom),
                 "R3/R4/R8/R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule